// File: doc/BRIEF.md
# ATA Channel Hidden Timing Register Bank

This block sits between a host access port and the task-file registers of one ATA channel. The channel's address window is normally passed straight through to the drive. A keyed write to one offset of that window opens a hidden bank of configuration registers, and another keyed write closes it. While the bank is open, the same offsets reach per-drive cycle timing registers, a control register, a read-only strap value and a miscellaneous register. None of these accesses reach the drive.

Two timing sets, A and B, each hold a read-cycle word and a write-cycle word. Bit 0 of the miscellaneous register selects which set a timing write goes to. Set B accepts writes only after the control register has opened it. The control register also decides whether drive 1 runs from set B or shares set A. The miscellaneous register also carries the address-setup, ready-delay and prefetch fields that both drives share. The cycle timing generator that follows this block reads the resulting timing words and shared fields.

Top module: `ata_cfg_bank`

## Requirements
- R1: Reset leaves the window closed with `cfg_open`=0. All stored registers are cleared, so every timing output, shared field and the set index read back as 0, which selects set A.
- R2: While closed, a write of 0x03 to offset 2 opens the window (`cfg_open`=1 from the next cycle). This write is consumed and does not reach the drive port.
- R3: While open, a write of 0x83 to offset 2 closes the window. Any other write to offset 2 while open is ignored and the window stays open.
- R4: While closed, every access except the opening key appears unchanged on the drive port (valid, direction, offset, data), and `host_rdata` equals `drv_rdata`. No bank register changes.
- R5: While open, no access reaches the drive port (`drv_valid`=0).
- R6: An open write to offset 6 stores the whole byte in the miscellaneous register. Bit 0 is the set index (0 = A, 1 = B). The outputs take their fields from that byte: `prefetch_en` from bit 6, `addr_setup` from bits 5:4 and `rdy_delay` from bits 2:1.
- R7: An open write to offset 0 loads the read-timing word and a write to offset 1 loads the write-timing word, each in the indexed set. A write to set B takes effect only while control bit 6 is 1; otherwise it is ignored.
- R8: An open write to offset 3 stores the control byte. Drive 0 always uses set A. Drive 1 uses set B when control bit 0 is 1 and set A when it is 0.
- R9: Open reads return the stored values. Offsets 0 and 1 return the indexed set's read and write words, offset 3 the control byte, offset 6 the miscellaneous byte and offset 5 the strap parameter. Offsets 2, 4 and 7 return 0xFF.
- R10: Open writes to offsets 5, 4 and 7 have no effect on any register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host access strobe, one cycle per access |
| host_write | input | 1 | 1 = write, 0 = read |
| host_ofs | input | 3 | Offset within the channel window |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data (bank value when open, drive value when closed) |
| drv_valid | output | 1 | Access forwarded to the drive |
| drv_write | output | 1 | Forwarded direction |
| drv_ofs | output | 3 | Forwarded offset |
| drv_wdata | output | 8 | Forwarded write data |
| drv_rdata | input | 8 | Drive read data |
| d0_rd_timing | output | 8 | Drive 0 read-cycle timing word |
| d0_wr_timing | output | 8 | Drive 0 write-cycle timing word |
| d1_rd_timing | output | 8 | Drive 1 read-cycle timing word |
| d1_wr_timing | output | 8 | Drive 1 write-cycle timing word |
| addr_setup | output | 2 | Shared address-setup field |
| rdy_delay | output | 2 | Shared ready-delay field |
| prefetch_en | output | 1 | Shared read prefetch enable |
| cfg_open | output | 1 | Configuration window is open |

## Verification
The embedded properties check on every cycle that an open window never forwards to the drive. They also check that closed accesses and writes to a locked set B leave the bank untouched, and that the open and close keys move the window state. The directed scenarios cover what those properties cannot see. These include the exact field positions on the shared outputs, which set each drive 1 mapping selects, readback of every offset including the 0xFF fill, and keys written with the wrong value or in the wrong state.

// File: rtl/ata_cfg_pkg.sv
package ata_cfg_pkg;
  localparam int OFS_W  = 3;
  localparam int DATA_W = 8;

  localparam logic [OFS_W-1:0] OFS_RD_TIM = 3'd0;
  localparam logic [OFS_W-1:0] OFS_WR_TIM = 3'd1;
  localparam logic [OFS_W-1:0] OFS_KEY    = 3'd2;
  localparam logic [OFS_W-1:0] OFS_CTRL   = 3'd3;
  localparam logic [OFS_W-1:0] OFS_STRAP  = 3'd5;
  localparam logic [OFS_W-1:0] OFS_MISC   = 3'd6;

  localparam logic [DATA_W-1:0] KEY_OPEN  = 8'h03;
  localparam logic [DATA_W-1:0] KEY_CLOSE = 8'h83;
  localparam logic [DATA_W-1:0] FILL_BYTE = 8'hFF;

  // control byte fields
  localparam int CTRL_D1_B_BIT  = 0;
  localparam int CTRL_B_OPEN_BIT = 6;
  // miscellaneous byte fields
  localparam int MISC_IDX_BIT  = 0;
  localparam int MISC_PF_BIT   = 6;
  localparam int MISC_AS_LO    = 4;
  localparam int MISC_RD_LO    = 1;

  localparam int NUM_SETS = 2;

  typedef struct packed {
    logic [DATA_W-1:0] rd;
    logic [DATA_W-1:0] wr;
  } timing_set_t;
endpackage

// File: rtl/cfg_reset_sync.sv
module cfg_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/cfg_window_ctl.sv
module cfg_window_ctl
  import ata_cfg_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_wr,
  input  logic [DW-1:0] wdata,
  output logic          open_q,
  output logic          key_hit
);
  logic open_d;
  logic is_open_key;
  logic is_close_key;

  always_comb begin
    is_open_key  = (wdata == DW'(KEY_OPEN));
    is_close_key = (wdata == DW'(KEY_CLOSE));
    key_hit      = key_wr && !open_q && is_open_key;
    open_d       = open_q;
    if (key_wr) begin
      if (!open_q && is_open_key)      open_d = 1'b1;
      else if (open_q && is_close_key) open_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= 1'b0;
    else        open_q <= open_d;
  end

  assert_unlock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && !open_q && wdata == DW'(KEY_OPEN)) |=> open_q);
  assert_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && open_q && wdata == DW'(KEY_CLOSE)) |=> !open_q);
  assert_stay_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && !(key_wr && wdata == DW'(KEY_CLOSE))) |=> open_q);
endmodule

// File: rtl/cfg_timing_set.sv
module cfg_timing_set
  import ata_cfg_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_we,
  input  logic          wr_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_q,
  output logic [DW-1:0] wr_q
);
  logic [DW-1:0] rd_d;
  logic [DW-1:0] wr_d;

  always_comb begin
    rd_d = rd_we ? wdata : rd_q;
    wr_d = wr_we ? wdata : wr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
      wr_q <= '0;
    end else begin
      if (rd_we) rd_q <= rd_d;
      if (wr_we) wr_q <= wr_d;
    end
  end
endmodule

// File: rtl/cfg_readback.sv
module cfg_readback
  import ata_cfg_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = OFS_W
) (
  input  logic [AW-1:0] ofs,
  input  logic          idx,
  input  logic [DW-1:0] a_rd,
  input  logic [DW-1:0] a_wr,
  input  logic [DW-1:0] b_rd,
  input  logic [DW-1:0] b_wr,
  input  logic [DW-1:0] ctrl,
  input  logic [DW-1:0] misc,
  input  logic [DW-1:0] strap,
  output logic [DW-1:0] rdata
);
  always_comb begin
    case (ofs)
      AW'(OFS_RD_TIM): rdata = idx ? b_rd : a_rd;
      AW'(OFS_WR_TIM): rdata = idx ? b_wr : a_wr;
      AW'(OFS_CTRL):   rdata = ctrl;
      AW'(OFS_STRAP):  rdata = strap;
      AW'(OFS_MISC):   rdata = misc;
      default:         rdata = DW'(FILL_BYTE);
    endcase
  end
endmodule

// File: rtl/ata_cfg_bank.sv
module ata_cfg_bank
  import ata_cfg_pkg::*;
#(
  parameter int          DW        = DATA_W,
  parameter int          AW        = OFS_W,
  parameter logic [7:0]  STRAP_VAL = 8'hA5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_valid,
  input  logic          host_write,
  input  logic [AW-1:0] host_ofs,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          drv_valid,
  output logic          drv_write,
  output logic [AW-1:0] drv_ofs,
  output logic [DW-1:0] drv_wdata,
  input  logic [DW-1:0] drv_rdata,
  output logic [DW-1:0] d0_rd_timing,
  output logic [DW-1:0] d0_wr_timing,
  output logic [DW-1:0] d1_rd_timing,
  output logic [DW-1:0] d1_wr_timing,
  output logic [1:0]    addr_setup,
  output logic [1:0]    rdy_delay,
  output logic          prefetch_en,
  output logic          cfg_open
);
  localparam int NS = NUM_SETS;

  logic          rst_n_s;
  logic          open_q;
  logic          key_wr;
  logic          key_hit;
  logic          cfg_wr;
  logic [DW-1:0] ctrl_q, ctrl_d;
  logic [DW-1:0] misc_q, misc_d;
  logic          ctrl_en, misc_en;
  logic          idx;
  logic          b_unlocked;
  logic [NS-1:0] set_rd_we;
  logic [NS-1:0] set_wr_we;
  logic [DW-1:0] set_rd [NS];
  logic [DW-1:0] set_wr [NS];
  logic [DW-1:0] cfg_rdata;

  cfg_reset_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  assign key_wr = host_valid && host_write && (host_ofs == AW'(OFS_KEY));

  cfg_window_ctl #(.DW(DW)) u_win (
    .clk(clk), .rst_n(rst_n_s), .key_wr(key_wr), .wdata(host_wdata),
    .open_q(open_q), .key_hit(key_hit)
  );

  assign cfg_open   = open_q;
  assign cfg_wr     = host_valid && host_write && open_q;
  assign idx        = misc_q[MISC_IDX_BIT];
  assign b_unlocked = ctrl_q[CTRL_B_OPEN_BIT];

  // control and miscellaneous next state
  always_comb begin
    ctrl_en = cfg_wr && (host_ofs == AW'(OFS_CTRL));
    misc_en = cfg_wr && (host_ofs == AW'(OFS_MISC));
    ctrl_d  = ctrl_en ? host_wdata : ctrl_q;
    misc_d  = misc_en ? host_wdata : misc_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ctrl_q <= '0;
      misc_q <= '0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (misc_en) misc_q <= misc_d;
    end
  end

  // timing sets, steered by the index; set B gated by control
  for (genvar s = 0; s < NS; s++) begin : g_set
    logic sel;
    if (s == 0) begin : g_a
      assign sel = (idx == 1'b0);
    end else begin : g_b
      assign sel = (idx == 1'b1) && b_unlocked;
    end
    assign set_rd_we[s] = cfg_wr && sel && (host_ofs == AW'(OFS_RD_TIM));
    assign set_wr_we[s] = cfg_wr && sel && (host_ofs == AW'(OFS_WR_TIM));
    cfg_timing_set #(.DW(DW)) u_set (
      .clk(clk), .rst_n(rst_n_s),
      .rd_we(set_rd_we[s]), .wr_we(set_wr_we[s]), .wdata(host_wdata),
      .rd_q(set_rd[s]), .wr_q(set_wr[s])
    );
  end

  cfg_readback #(.DW(DW), .AW(AW)) u_rb (
    .ofs(host_ofs), .idx(idx),
    .a_rd(set_rd[0]), .a_wr(set_wr[0]), .b_rd(set_rd[1]), .b_wr(set_wr[1]),
    .ctrl(ctrl_q), .misc(misc_q), .strap(DW'(STRAP_VAL)), .rdata(cfg_rdata)
  );

  // drive pass-through
  always_comb begin
    drv_valid  = host_valid && !open_q && !key_hit;
    drv_write  = host_write;
    drv_ofs    = host_ofs;
    drv_wdata  = host_wdata;
    host_rdata = open_q ? cfg_rdata : drv_rdata;
  end

  // per-drive outputs and shared fields
  always_comb begin
    d0_rd_timing = set_rd[0];
    d0_wr_timing = set_wr[0];
    d1_rd_timing = ctrl_q[CTRL_D1_B_BIT] ? set_rd[1] : set_rd[0];
    d1_wr_timing = ctrl_q[CTRL_D1_B_BIT] ? set_wr[1] : set_wr[0];
    addr_setup   = misc_q[MISC_AS_LO+1:MISC_AS_LO];
    rdy_delay    = misc_q[MISC_RD_LO+1:MISC_RD_LO];
    prefetch_en  = misc_q[MISC_PF_BIT];
  end

  assert_closed_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (host_valid && !open_q) |=> ($stable(ctrl_q) && $stable(misc_q) &&
      $stable(set_rd[0]) && $stable(set_wr[0]) &&
      $stable(set_rd[1]) && $stable(set_wr[1])));
  assert_no_drive_open_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    open_q |-> !drv_valid);
  assert_b_locked_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (host_valid && host_write && idx && !b_unlocked) |=>
      ($stable(set_rd[1]) && $stable(set_wr[1])));
  assert_a_kept_on_b_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (host_valid && host_write && idx && !(host_ofs == AW'(OFS_MISC))) |=>
      ($stable(set_rd[0]) && $stable(set_wr[0])));
endmodule

// File: tb/ata_cfg_bank_bench.sv
module ata_cfg_bank_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_valid, host_write;
  logic [2:0] host_ofs;
  logic [7:0] host_wdata, host_rdata;
  logic       drv_valid, drv_write;
  logic [2:0] drv_ofs;
  logic [7:0] drv_wdata, drv_rdata;
  logic [7:0] d0_rd, d0_wr, d1_rd, d1_wr;
  logic [1:0] addr_setup, rdy_delay;
  logic       prefetch_en, cfg_open;

  int total = 0;
  int bad   = 0;
  logic [7:0] rd_val;
  logic       seen_drv;

  always #4 clk = ~clk;

  assign drv_rdata = {5'b01010, drv_ofs};

  ata_cfg_bank u_ata_cfg_bank (
    .clk(clk), .rst_n(rst_n),
    .host_valid(host_valid), .host_write(host_write), .host_ofs(host_ofs),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .drv_valid(drv_valid), .drv_write(drv_write), .drv_ofs(drv_ofs),
    .drv_wdata(drv_wdata), .drv_rdata(drv_rdata),
    .d0_rd_timing(d0_rd), .d0_wr_timing(d0_wr),
    .d1_rd_timing(d1_rd), .d1_wr_timing(d1_wr),
    .addr_setup(addr_setup), .rdy_delay(rdy_delay),
    .prefetch_en(prefetch_en), .cfg_open(cfg_open)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [2:0] ofs, input logic [7:0] data);
    @(negedge clk);
    host_valid = 1'b1; host_write = wr; host_ofs = ofs; host_wdata = data;
    #1;
    rd_val   = host_rdata;
    seen_drv = drv_valid;
    @(posedge clk);
    #1;
    host_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 open", {7'd0, cfg_open}, 8'h00);
    chk("R1 d0rd", d0_rd, 8'h00);
    chk("R1 d1wr", d1_wr, 8'h00);
    chk("R1 fields", {3'd0, prefetch_en, addr_setup, rdy_delay}, 8'h00);
  endtask

  task automatic t_pass;
    acc(1'b1, 3'd4, 8'h3C);
    chk("R4 fwd valid", {7'd0, seen_drv}, 8'h01);
    chk("R4 fwd data", drv_wdata, 8'h3C);
    acc(1'b0, 3'd1, 8'h00);
    chk("R4 rdata", rd_val, 8'h51);
    acc(1'b1, 3'd2, 8'h83);  // wrong key while closed: forwarded
    chk("R4 key off", {7'd0, seen_drv}, 8'h01);
    chk("R3 still closed", {7'd0, cfg_open}, 8'h00);
    acc(1'b1, 3'd6, 8'h71);  // closed misc write must not land
    chk("R4 misc frozen", {3'd0, prefetch_en, addr_setup, rdy_delay}, 8'h00);
  endtask

  task automatic t_unlock;
    acc(1'b1, 3'd2, 8'h03);
    chk("R2 consumed", {7'd0, seen_drv}, 8'h00);
    chk("R2 opened", {7'd0, cfg_open}, 8'h01);
    acc(1'b1, 3'd2, 8'h55);
    chk("R3 other key", {7'd0, cfg_open}, 8'h01);
    acc(1'b0, 3'd4, 8'h00);
    chk("R5 no drive", {7'd0, seen_drv}, 8'h00);
  endtask

  task automatic t_timing;
    acc(1'b1, 3'd0, 8'h21);  // set A read
    acc(1'b1, 3'd1, 8'h32);  // set A write
    chk("R7 A rd", d0_rd, 8'h21);
    chk("R7 A wr", d0_wr, 8'h32);
    acc(1'b1, 3'd6, 8'h01);  // index B, B still locked
    acc(1'b1, 3'd0, 8'h99);
    chk("R7 locked B", d0_rd, 8'h21);
    acc(1'b0, 3'd0, 8'h00);
    chk("R7 B unwritten", rd_val, 8'h00);
    acc(1'b1, 3'd3, 8'hC0);  // open set B
    acc(1'b1, 3'd0, 8'h47);
    acc(1'b1, 3'd1, 8'h58);
    acc(1'b0, 3'd0, 8'h00);
    chk("R9 B rd", rd_val, 8'h47);
    chk("R8 d1 on A", d1_rd, 8'h21);
  endtask

  task automatic t_map;
    acc(1'b1, 3'd3, 8'h85);
    chk("R8 d1 rd B", d1_rd, 8'h47);
    chk("R8 d1 wr B", d1_wr, 8'h58);
    chk("R8 d0 A", d0_wr, 8'h32);
    acc(1'b1, 3'd6, 8'h76);  // pf=1 as=3 rdy=3 idx=0
    chk("R6 fields", {3'd0, prefetch_en, addr_setup, rdy_delay}, 8'h1F);
    acc(1'b1, 3'd6, 8'h12);  // pf=0 as=1 rdy=1
    chk("R6 fields2", {3'd0, prefetch_en, addr_setup, rdy_delay}, 8'h05);
  endtask

  task automatic t_readback;
    acc(1'b0, 3'd0, 8'h00); chk("R9 A rd", rd_val, 8'h21);
    acc(1'b0, 3'd1, 8'h00); chk("R9 A wr", rd_val, 8'h32);
    acc(1'b0, 3'd3, 8'h00); chk("R9 ctrl", rd_val, 8'h85);
    acc(1'b0, 3'd5, 8'h00); chk("R9 strap", rd_val, 8'hA5);
    acc(1'b0, 3'd6, 8'h00); chk("R9 misc", rd_val, 8'h12);
    acc(1'b0, 3'd2, 8'h00); chk("R9 fill2", rd_val, 8'hFF);
    acc(1'b0, 3'd7, 8'h00); chk("R9 fill7", rd_val, 8'hFF);
    acc(1'b1, 3'd5, 8'hFF);
    acc(1'b1, 3'd4, 8'h11);
    acc(1'b1, 3'd7, 8'h22);
    acc(1'b0, 3'd5, 8'h00); chk("R10 strap kept", rd_val, 8'hA5);
    acc(1'b0, 3'd4, 8'h00); chk("R10 fill4", rd_val, 8'hFF);
    chk("R10 d0rd", d0_rd, 8'h21);
    chk("R10 fields", {3'd0, prefetch_en, addr_setup, rdy_delay}, 8'h05);
  endtask

  task automatic t_lock;
    acc(1'b1, 3'd2, 8'h83);
    chk("R3 closed", {7'd0, cfg_open}, 8'h00);
    acc(1'b0, 3'd3, 8'h00);
    chk("R4 after close", rd_val, 8'h53);
    chk("R4 fwd again", {7'd0, seen_drv}, 8'h01);
    chk("R8 map kept", d1_rd, 8'h47);
  endtask

  initial begin
    #(8 * 20000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    host_valid = 1'b0; host_write = 1'b0; host_ofs = '0; host_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_pass();
    t_unlock();
    t_timing();
    t_map();
    t_readback();
    t_lock();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule